// File: doc/BRIEF.md
# Sample Rate Measurement Encoder

This block estimates the sample rate of a received digital audio stream. It counts rising edges of a fixed reference clock (nominally 6.144 MHz) over a measurement window of received frames. It then compares that count against tolerance bands, one per supported rate, and reports a 3-bit rate code with a valid flag. A channel status block of `FRAMES_PER_BLOCK` frames is split into `UPDATES_PER_BLOCK` equal windows, so the code refreshes three times per block. The first refresh falls on the block start strobe.

The block runs on a fast system clock `clk`. The reference clock and the PLL lock indicator are asynchronous levels and pass through a two-flop synchronizer. The frame and block strobes are single-cycle pulses synchronous to `clk`, and a block start is signalled by asserting `block_stb_i` together with that frame's `frame_stb_i`. A window is measured only if it was clean. Clean means the PLL stayed locked and reference clock edges kept arriving, with no gap longer than `REF_TIMEOUT` clock cycles. The outputs are plain status levels with no handshake: the consumer may sample them at any time, and there is no back-pressure.

Top module: `srate_meter`

## Requirements
- R1: After reset, `rate_valid_o` is 0 and `rate_code_o` is 000.
- R2: The window count is the number of reference clock rising edges seen during the window. Each supported rate has a nominal count N = window_frames × REF_HZ / rate, using integer division. A rate matches when the count lies in the half-open range [N×96/100, N×104/100), again using integer division. The rate codes are 001 = 32 kHz, 010 = 44.1 kHz, 011 = 48 kHz, 100 = 88.2 kHz and 101 = 96 kHz.
- R3: A window is FRAMES_PER_BLOCK/UPDATES_PER_BLOCK frames long and is aligned to the block start. The code changes only at a window boundary, one or two cycles after the boundary strobe, or on a loss event; otherwise it holds its value.
- R4: `rate_valid_o` rises only after two consecutive clean full windows (two thirds of a block) since reset or since the last loss. The code of the second such window is presented with it.
- R5: While the synchronized PLL lock is low, `rate_valid_o` is 0 and `rate_code_o` is 000 within 3 cycles, and qualification restarts.
- R6: If no reference clock edge arrives for `REF_TIMEOUT` cycles, the block behaves as for a PLL loss.
- R7: If a loss and a window boundary fall in the same cycle, the loss wins. That window is not used, and the outputs are cleared.
- R8: A window cut short by an early block start (fewer than the full frame count) is discarded. It changes neither the code, nor the valid flag, nor the qualification progress.
- R9: A count that lies in no range gives code 000 with `rate_valid_o` still 1, once the block is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Reference clock level, sampled through a synchronizer |
| frame_stb_i | input | 1 | One-cycle pulse per received frame |
| block_stb_i | input | 1 | Block start, valid only together with frame_stb_i |
| pll_lock_i | input | 1 | PLL lock indicator level, asynchronous |
| rate_code_o | output | 3 | Rate code (R2 encoding) |
| rate_valid_o | output | 1 | Rate code is qualified and current |

## Verification
A loss event and a window boundary can fall in the same cycle. Both want to write the output registers: the boundary wants to publish a new code, and the loss wants to clear everything. The bench provokes this by dropping `pll_lock_i` exactly three clock edges before the strobe that closes a full, otherwise clean window, which accounts for the two synchronizer stages. Without the loss, that boundary would have kept `rate_valid_o` high. The bench judges the result by requiring `rate_valid_o` = 0 and code 000 after that boundary. It then requires two further clean windows before the flag returns.

// File: rtl/srate_pkg.sv
package srate_pkg;

  localparam int unsigned NUM_RATES = 5;

  typedef logic [2:0] rate_code_t;

  // Supported rates, lowest first; code of entry i is i+1.
  function automatic int unsigned rate_hz(input int unsigned idx);
    case (idx)
      0:       return 32000;
      1:       return 44100;
      2:       return 48000;
      3:       return 88200;
      default: return 96000;
    endcase
  endfunction

  function automatic int unsigned nominal_count(input int unsigned win_frames,
                                                input int unsigned ref_hz,
                                                input int unsigned fs);
    longint unsigned prod;
    prod = longint'(win_frames) * longint'(ref_hz);
    return int'(prod / longint'(fs));
  endfunction

  function automatic int unsigned scale_pct(input int unsigned value,
                                            input int unsigned pct);
    longint unsigned prod;
    prod = longint'(value) * longint'(pct);
    return int'(prod / 64'd100);
  endfunction

endpackage

// File: rtl/srate_sync.sv
module srate_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/srate_ref_watch.sv
module srate_ref_watch #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_s,
  output logic tick,
  output logic alive
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TO_LIMIT = TW'(TIMEOUT);

  logic          ref_d;
  logic [TW-1:0] idle_cnt;

  assign tick  = ref_s && !ref_d;
  assign alive = (idle_cnt != TO_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d    <= 1'b0;
      idle_cnt <= TO_LIMIT;
    end else begin
      ref_d <= ref_s;
      if (tick)
        idle_cnt <= '0;
      else if (idle_cnt != TO_LIMIT)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_TICK_REVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> alive); // R6
endmodule

// File: rtl/srate_window.sv
module srate_window #(
  parameter int unsigned WIN_FRAMES = 64,
  parameter int unsigned CNT_W      = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic             block_stb,
  input  logic             tick,
  input  logic             loss,
  output logic             done,
  output logic             full,
  output logic             clean,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned FW = $clog2(WIN_FRAMES + 1);
  localparam logic [FW-1:0] FULL_FRAMES = FW'(WIN_FRAMES);

  logic [FW-1:0]    fcnt;
  logic [CNT_W-1:0] ticks;
  logic             aligned;
  logic             clean_r;
  logic             at_end;
  logic             boundary;

  assign at_end   = aligned && (fcnt == FULL_FRAMES);
  assign boundary = frame_stb && (block_stb || at_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt    <= '0;
      ticks   <= '0;
      aligned <= 1'b0;
      clean_r <= 1'b0;
      done    <= 1'b0;
      full    <= 1'b0;
      clean   <= 1'b0;
      count   <= '0;
    end else begin
      done <= boundary && aligned;
      if (boundary) begin
        full    <= (fcnt == FULL_FRAMES);
        clean   <= clean_r && !loss;
        count   <= ticks;
        fcnt    <= FW'(1);
        ticks   <= tick ? CNT_W'(1) : '0;
        clean_r <= !loss;
      end else begin
        if (frame_stb && (fcnt != FULL_FRAMES))
          fcnt <= fcnt + 1'b1;
        if (tick && (ticks != '1))
          ticks <= ticks + 1'b1;
        if (loss)
          clean_r <= 1'b0;
      end
      if (frame_stb && block_stb)
        aligned <= 1'b1;
    end
  end

  AST_FRAME_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FULL_FRAMES); // R3
  AST_NO_DONE_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |=> !done); // R3
endmodule

// File: rtl/srate_classify.sv
module srate_classify
  import srate_pkg::*;
#(
  parameter int unsigned WIN_FRAMES = 64,
  parameter int unsigned REF_HZ     = 6144000,
  parameter int unsigned TOL_PCT    = 4,
  parameter int unsigned CNT_W      = 15
) (
  input  logic [CNT_W-1:0]     count,
  output logic [NUM_RATES-1:0] hit,
  output rate_code_t           code
);
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_band
    localparam int unsigned NOM = nominal_count(WIN_FRAMES, REF_HZ, rate_hz(g));
    localparam logic [CNT_W-1:0] LO = CNT_W'(scale_pct(NOM, 100 - TOL_PCT));
    localparam logic [CNT_W-1:0] HI = CNT_W'(scale_pct(NOM, 100 + TOL_PCT));
    assign hit[g] = (count >= LO) && (count < HI);
  end

  always_comb begin
    code = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hit[i])
        code = rate_code_t'(i + 1);
    end
  end
endmodule

// File: rtl/srate_meter.sv
module srate_meter
  import srate_pkg::*;
#(
  parameter int unsigned FRAMES_PER_BLOCK  = 192,
  parameter int unsigned UPDATES_PER_BLOCK = 3,
  parameter int unsigned REF_HZ            = 6144000,
  parameter int unsigned TOL_PCT           = 4,
  parameter int unsigned REF_TIMEOUT       = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk_i,
  input  logic       frame_stb_i,
  input  logic       block_stb_i,
  input  logic       pll_lock_i,
  output logic [2:0] rate_code_o,
  output logic       rate_valid_o
);
  localparam int unsigned WIN_FRAMES   = FRAMES_PER_BLOCK / UPDATES_PER_BLOCK;
  localparam int unsigned QUAL_WINDOWS = (2 * UPDATES_PER_BLOCK + 2) / 3;
  localparam int unsigned MAX_NOM      = nominal_count(WIN_FRAMES, REF_HZ, rate_hz(0));
  localparam int unsigned CNT_W        = $clog2(2 * MAX_NOM);
  localparam int unsigned QW           = $clog2(QUAL_WINDOWS + 1);
  localparam logic [QW-1:0] QUAL_DONE  = QW'(QUAL_WINDOWS);

  logic [1:0]           sync_q;
  logic                 lock_s;
  logic                 ref_s;
  logic                 ref_tick;
  logic                 ref_alive;
  logic                 loss;
  logic                 win_done;
  logic                 win_full;
  logic                 win_clean;
  logic [CNT_W-1:0]     win_count;
  logic [NUM_RATES-1:0] rate_hits;
  rate_code_t           class_code;
  logic [QW-1:0]        qual;
  logic [QW-1:0]        qual_next;

  srate_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pll_lock_i, ref_clk_i}),
    .q     (sync_q)
  );
  assign lock_s = sync_q[1];
  assign ref_s  = sync_q[0];

  srate_ref_watch #(.TIMEOUT(REF_TIMEOUT)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .ref_s (ref_s),
    .tick  (ref_tick),
    .alive (ref_alive)
  );

  assign loss = !lock_s || !ref_alive;

  srate_window #(.WIN_FRAMES(WIN_FRAMES), .CNT_W(CNT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb_i),
    .block_stb (block_stb_i),
    .tick      (ref_tick),
    .loss      (loss),
    .done      (win_done),
    .full      (win_full),
    .clean     (win_clean),
    .count     (win_count)
  );

  srate_classify #(
    .WIN_FRAMES (WIN_FRAMES),
    .REF_HZ     (REF_HZ),
    .TOL_PCT    (TOL_PCT),
    .CNT_W      (CNT_W)
  ) u_classify (
    .count (win_count),
    .hit   (rate_hits),
    .code  (class_code)
  );

  assign qual_next = (qual == QUAL_DONE) ? qual : qual + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual         <= '0;
      rate_valid_o <= 1'b0;
      rate_code_o  <= '0;
    end else if (loss) begin
      qual         <= '0;
      rate_valid_o <= 1'b0;
      rate_code_o  <= '0;
    end else if (win_done && win_full && win_clean) begin
      qual <= qual_next;
      if (qual_next == QUAL_DONE) begin
        rate_valid_o <= 1'b1;
        rate_code_o  <= class_code;
      end
    end
  end

  AST_ONE_RATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rate_hits)); // R2
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(win_done) && !$past(loss)) |-> $stable(rate_code_o)); // R3
  AST_VALID_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_valid_o) |-> $past(win_done && win_full && win_clean && !loss)); // R4
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_s |=> (!rate_valid_o && rate_code_o == 3'b000)); // R5
  AST_REF_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_alive |=> !rate_valid_o); // R6
  AST_LOSS_BEATS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && loss) |=> !rate_valid_o); // R7
  AST_SHORT_WINDOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_done && !win_full && !loss) |-> ($stable(rate_valid_o) && $stable(rate_code_o))); // R8
endmodule

// File: tb/tb_srate_meter.sv
`timescale 1ns/1ps
module tb_srate_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk_i;
  logic       frame_stb_i = 1'b0;
  logic       block_stb_i = 1'b0;
  logic       pll_lock_i = 1'b0;
  logic [2:0] rate_code_o;
  logic       rate_valid_o;

  logic [1:0] ref_ph = 2'b00;
  logic       ref_en = 1'b0;
  int         n_run = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  // Reference edge every 4 clk; a 4-frame window of P clk per frame counts P edges.
  localparam int VEC_N = 13;
  localparam int VEC_PER  [VEC_N] = '{512, 557, 768, 256, 279, 410, 491, 490, 531, 532, 265, 266, 797};
  localparam int VEC_CODE [VEC_N] = '{3,   2,   1,   5,   4,   0,   3,   0,   3,   0,   5,   4,   1};

  always #2.5 clk = ~clk;
  assign ref_clk_i = ref_ph[1];

  srate_meter #(.FRAMES_PER_BLOCK(12), .REF_TIMEOUT(32)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_clk_i    (ref_clk_i),
    .frame_stb_i  (frame_stb_i),
    .block_stb_i  (block_stb_i),
    .pll_lock_i   (pll_lock_i),
    .rate_code_o  (rate_code_o),
    .rate_valid_o (rate_valid_o)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (ref_en) ref_ph = ref_ph + 2'd1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input bit blk, input int per);
    frame_stb_i = 1'b1;
    block_stb_i = blk;
    @(posedge clk); #1;
    frame_stb_i = 1'b0;
    block_stb_i = 1'b0;
    repeat (per - 1) @(posedge clk);
    #1;
  endtask

  task automatic frames(input int n, input int per);
    for (int k = 0; k < n; k++) frame(1'b0, per);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (10) @(posedge clk); #1;
    chk("R1 valid", int'(rate_valid_o), 0);
    chk("R1 code", int'(rate_code_o), 0);
    rst_n = 1'b1; pll_lock_i = 1'b1; ref_en = 1'b1;
    repeat (20) @(posedge clk); #1;
    chk("R4 no frames yet", int'(rate_valid_o), 0);

    // Qualification from reset at 48 kHz
    frame(1'b1, 512);
    frames(4, 512);
    chk("R4 one window", int'(rate_valid_o), 0);
    frames(4, 512);
    chk("R4 two windows", int'(rate_valid_o), 1);
    chk("R3 first code", int'(rate_code_o), 3);
    frames(3, 512);
    prev = 3;

    // Rate table: each entry runs one block
    for (int i = 0; i < VEC_N; i++) begin
      frame(1'b1, VEC_PER[i]);
      frames(3, VEC_PER[i]);
      chk("R3 hold mid-window", int'(rate_code_o), prev);
      frame(1'b0, VEC_PER[i]);
      chk((VEC_CODE[i] == 0) ? "R9 code" : "R2 code", int'(rate_code_o), VEC_CODE[i]);
      chk("R9 valid", int'(rate_valid_o), 1);
      frames(7, VEC_PER[i]);
      prev = VEC_CODE[i];
    end

    // R8: early block start cuts a window short
    frame(1'b1, 256);
    frame(1'b0, 256);
    frame(1'b1, 256);
    chk("R8 code kept", int'(rate_code_o), 1);
    chk("R8 valid kept", int'(rate_valid_o), 1);
    frames(4, 256);
    chk("R8 resumes", int'(rate_code_o), 5);
    frames(7, 256);

    // R5: unlock mid-window
    frame(1'b1, 256);
    frame(1'b0, 256);
    pll_lock_i = 1'b0;
    repeat (6) @(posedge clk); #1;
    chk("R5 valid", int'(rate_valid_o), 0);
    chk("R5 code", int'(rate_code_o), 0);
    pll_lock_i = 1'b1;
    repeat (10) @(posedge clk); #1;
    frames(7, 256);
    chk("R5 one clean window", int'(rate_valid_o), 0);
    frames(3, 256);
    frame(1'b1, 256);
    chk("R4 requalified", int'(rate_valid_o), 1);
    chk("R4 requalified code", int'(rate_code_o), 5);

    // R7: loss lands on the boundary edge
    frames(2, 256);
    frame(1'b0, 254);
    pll_lock_i = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    frame(1'b0, 256);
    chk("R7 valid", int'(rate_valid_o), 0);
    chk("R7 code", int'(rate_code_o), 0);
    pll_lock_i = 1'b1;
    frames(7, 256);
    frame(1'b1, 256);
    chk("R7 still qualifying", int'(rate_valid_o), 0);
    frames(4, 256);
    chk("R7 recovered", int'(rate_valid_o), 1);

    // R6: reference clock stops
    ref_en = 1'b0;
    repeat (60) @(posedge clk); #1;
    chk("R6 valid", int'(rate_valid_o), 0);
    chk("R6 code", int'(rate_code_o), 0);
    ref_en = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule